// File: doc/BRIEF.md
# Public-Key Engine Control Front End

This block sits between software and a modular-exponentiation accelerator. Software uses a 32-bit register port to program three values: where the operands live in system memory, how many bytes to move, and the exponent and modulus bit lengths packed into one word. It then selects the memory mode that hands the local data memory to the engine, unmasks completion, and writes the trigger register. The block copies the operands into local SRAM through a simple read-request master, runs the arithmetic stage, and raises a level interrupt when that stage finishes.

The arithmetic core is stood in for by a stub that reports done a fixed number of cycles after it starts. A state machine controls the sequence. ST_IDLE waits for an accepted trigger. On start-fetch it moves to ST_FETCH; on start-compute alone it moves to ST_CALC. ST_FETCH moves to ST_CALC when the last word lands, if the compute bit was also set; otherwise it moves to ST_DONE. ST_CALC moves to ST_DONE when the stub reports done. ST_DONE holds. From any state, a trigger write with both start bits clear aborts and returns to ST_IDLE.

Top module: `pke_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `dma_req` is low.
- R2: Registers sit at byte offsets 0x000 (trigger, bits 1:0), 0x048 (memory command: bit 8 = CPU owns data memory, bits 5:4 = fill mode), 0x04C (source base), 0x050 (byte length), 0x058 (bit lengths: exponent in [31:16], modulus in [15:0]), 0x3F8 (mask, bit 1) and 0x3FC (status, bit 1). Unimplemented bits read zero. `mem_cpu_access` follows command bit 8.
- R3: In the trigger register, bit 1 starts the operand fetch and bit 0 starts the compute stage. A trigger is accepted only when command bits 5:4 are 2'b11 and bit 8 is 0. A rejected trigger starts nothing and the trigger register still reads 0.
- R4: The fetch issues ceil(length/4) reads at base, base+4, and so on. It issues at most one read per cycle. `dma_req` and `dma_addr` hold steady until `dma_gnt`.
- R5: Each word returned with `dma_rvalid` is written to SRAM word index 0, 1, 2 and so on, in order.
- R6: The compute stage starts after the fetch when both bits are set, or at once when only bit 0 is set. Status bit 1 is set CALC_CYCLES edges after the compute stage starts. A fetch-only trigger never sets it.
- R7: `irq` equals status bit 1 AND mask bit 1. It stays high until software clears it.
- R8: Writing 1 to status bit 1 clears it. Writing 0 to that bit leaves it unchanged.
- R9: A trigger with a start bit set is ignored while the block is not in ST_IDLE.
- R10: A trigger write with bits 1:0 both zero stops any activity at the next edge. The block returns to ST_IDLE, the trigger reads 0, and a later trigger is accepted.
- R11: A trigger is rejected when the modulus bit length exceeds MAX_MOD_BITS (4096). A length of exactly 4096 is accepted.
- R12: A zero byte length gives a fetch with no reads, followed directly by the next stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| dma_req | output | 1 | Read request to system memory |
| dma_addr | output | 32 | Read byte address |
| dma_gnt | input | 1 | Request accepted this cycle |
| dma_rvalid | input | 1 | Read data valid, one per accepted request |
| dma_rdata | input | 32 | Read data |
| sram_we | output | 1 | Local SRAM write strobe |
| sram_addr | output | SRAM_AW | Local SRAM word index |
| sram_wdata | output | 32 | Local SRAM write data |
| mem_cpu_access | output | 1 | Data memory handed to CPU bus |
| irq | output | 1 | Level completion interrupt |

## Verification
Full-size fetches run under a grant that drops every third cycle and under a grant that is always high. Together these separate a correct hold of request and address from skipped or repeated words, which the scoreboard sees as wrong SRAM contents. Lengths of 10 and 0 bytes test the rounding to whole words and the empty fetch. Compute-only runs, sampled one cycle before and at the expected edge, pin down the stub latency. Rejected triggers cover a wrong mode field, CPU ownership of memory, modulus 4097 against 4096, and triggers while busy. An abort in the middle of a fetch shows that requests stop and that a fresh run still starts.

// File: rtl/pke_pkg.sv
package pke_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CALC, ST_DONE} pke_state_e;

    localparam logic [11:0] OFF_TRIG   = 12'h000;
    localparam logic [11:0] OFF_CMD    = 12'h048;
    localparam logic [11:0] OFF_SRC    = 12'h04C;
    localparam logic [11:0] OFF_LEN    = 12'h050;
    localparam logic [11:0] OFF_KEYLEN = 12'h058;
    localparam logic [11:0] OFF_MASK   = 12'h3F8;
    localparam logic [11:0] OFF_STAT   = 12'h3FC;

    localparam int TRG_CALC  = 0;
    localparam int TRG_FETCH = 1;
    localparam int CMD_CPU   = 8;
    localparam int STAT_DONE = 1;
    localparam logic [1:0] CMD_FILL = 2'b11;
endpackage

// File: rtl/pke_operand_fetch.sv
module pke_operand_fetch #(
    parameter int SRAM_AW = 11,
    parameter int WCNT_W  = 12,
    localparam int LW = WCNT_W + 2,
    localparam int CW = WCNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [31:0]        base,
    input  logic [LW-1:0]      len_bytes,
    output logic               req,
    output logic [31:0]        addr,
    input  logic               gnt,
    input  logic               rvalid,
    input  logic [31:0]        rdata,
    output logic               we,
    output logic [SRAM_AW-1:0] waddr,
    output logic [31:0]        wdata,
    output logic               done
);
    logic          active_q;
    logic [CW-1:0] iss_q, rcv_q, nwords_q;
    logic [31:0]   base_q;
    logic [LW:0]   len_round;

    // byte count rounded up to whole 32-bit words
    assign len_round = {1'b0, len_bytes} + (LW+1)'(3);

    assign done  = active_q && (rcv_q == nwords_q);
    assign req   = active_q && (iss_q != nwords_q);
    assign addr  = base_q + 32'({iss_q, 2'b00});
    assign we    = active_q && rvalid && (rcv_q != nwords_q);
    assign waddr = rcv_q[SRAM_AW-1:0];
    assign wdata = rdata;

    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active_q <= 1'b0;
            iss_q    <= '0;
            rcv_q    <= '0;
            nwords_q <= '0;
            base_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            iss_q    <= '0;
            rcv_q    <= '0;
            nwords_q <= len_round[LW:2];
            base_q   <= base;
        end else if (active_q) begin
            if (done) active_q <= 1'b0;
            if (req && gnt) iss_q <= iss_q + 1'b1;
            if (we) rcv_q <= rcv_q + 1'b1;
        end
    end
endmodule

// File: rtl/pke_calc_stub.sv
module pke_calc_stub #(
    parameter int CALC_CYCLES = 16,
    localparam int CNT_W = $clog2(CALC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);
    logic             running_q;
    logic [CNT_W-1:0] cnt_q;

    assign done = running_q && (cnt_q == CNT_W'(CALC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
        end else if (running_q) begin
            if (done) running_q <= 1'b0;
            else      cnt_q     <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pke_ctrl.sv
module pke_ctrl
    import pke_pkg::*;
#(
    parameter int SRAM_AW      = 11,
    parameter int WCNT_W       = 12,
    parameter int CALC_CYCLES  = 16,
    parameter int MAX_MOD_BITS = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               dma_req,
    output logic [31:0]        dma_addr,
    input  logic               dma_gnt,
    input  logic               dma_rvalid,
    input  logic [31:0]        dma_rdata,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [31:0]        sram_wdata,
    output logic               mem_cpu_access,
    output logic               irq
);
    localparam int LW = WCNT_W + 2;

    pke_state_e  state_q, state_d;
    logic [31:0] src_q, len_q, keylen_q;
    logic [1:0]  trig_q, fill_q;
    logic        cpu_q, mask_q, stat_q;
    logic        wr, wr_trig, stop, trig_go, mode_ok, mod_ok;
    logic        fetch_start, fetch_done, calc_start, calc_done;

    assign wr      = bus_sel && bus_wr;
    assign wr_trig = wr && (bus_addr == OFF_TRIG);
    assign stop    = wr_trig && (bus_wdata[1:0] == 2'b00);
    assign mode_ok = (fill_q == CMD_FILL) && !cpu_q;
    assign mod_ok  = 32'(keylen_q[15:0]) <= 32'(MAX_MOD_BITS);
    assign trig_go = wr_trig && (bus_wdata[1:0] != 2'b00) && (state_q == ST_IDLE)
                     && mode_ok && mod_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and stage start strobes
    always_comb begin
        state_d     = state_q;
        fetch_start = 1'b0;
        calc_start  = 1'b0;
        if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig_go) begin
                    if (bus_wdata[TRG_FETCH]) begin
                        state_d     = ST_FETCH;
                        fetch_start = 1'b1;
                    end else begin
                        state_d    = ST_CALC;
                        calc_start = 1'b1;
                    end
                end
                ST_FETCH: if (fetch_done) begin
                    if (trig_q[TRG_CALC]) begin
                        state_d    = ST_CALC;
                        calc_start = 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
                ST_CALC: if (calc_done) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    // register file and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            len_q    <= '0;
            keylen_q <= '0;
            trig_q   <= '0;
            fill_q   <= '0;
            cpu_q    <= 1'b0;
            mask_q   <= 1'b0;
            stat_q   <= 1'b0;
        end else begin
            if (wr && bus_addr == OFF_SRC)    src_q    <= bus_wdata;
            if (wr && bus_addr == OFF_LEN)    len_q    <= bus_wdata;
            if (wr && bus_addr == OFF_KEYLEN) keylen_q <= bus_wdata;
            if (wr && bus_addr == OFF_MASK)   mask_q   <= bus_wdata[STAT_DONE];
            if (wr && bus_addr == OFF_CMD) begin
                fill_q <= bus_wdata[5:4];
                cpu_q  <= bus_wdata[CMD_CPU];
            end
            if (stop)         trig_q <= 2'b00;
            else if (trig_go) trig_q <= bus_wdata[1:0];
            if (state_q == ST_CALC && calc_done && !stop)
                stat_q <= 1'b1;
            else if (wr && bus_addr == OFF_STAT && bus_wdata[STAT_DONE])
                stat_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_TRIG:   bus_rdata = {30'b0, trig_q};
            OFF_CMD:    bus_rdata = {23'b0, cpu_q, 2'b0, fill_q, 4'b0};
            OFF_SRC:    bus_rdata = src_q;
            OFF_LEN:    bus_rdata = len_q;
            OFF_KEYLEN: bus_rdata = keylen_q;
            OFF_MASK:   bus_rdata = {30'b0, mask_q, 1'b0};
            OFF_STAT:   bus_rdata = {30'b0, stat_q, 1'b0};
            default:    bus_rdata = '0;
        endcase
    end

    assign irq            = stat_q && mask_q;
    assign mem_cpu_access = cpu_q;

    pke_operand_fetch #(.SRAM_AW(SRAM_AW), .WCNT_W(WCNT_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fetch_start), .abort(stop),
        .base(src_q), .len_bytes(len_q[LW-1:0]),
        .req(dma_req), .addr(dma_addr), .gnt(dma_gnt),
        .rvalid(dma_rvalid), .rdata(dma_rdata),
        .we(sram_we), .waddr(sram_addr), .wdata(sram_wdata),
        .done(fetch_done)
    );

    pke_calc_stub #(.CALC_CYCLES(CALC_CYCLES)) u_calc (
        .clk(clk), .rst_n(rst_n), .start(calc_start), .abort(stop),
        .done(calc_done)
    );
endmodule

// File: rtl/pke_ctrl_chk.sv
module pke_ctrl_chk
    import pke_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        dma_req,
    input logic        dma_gnt,
    input logic [31:0] dma_addr,
    input logic        dma_rvalid,
    input logic        sram_we,
    input logic        irq,
    input pke_state_e  state
);
    logic stop_w;
    assign stop_w = bus_sel && bus_wr && (bus_addr == OFF_TRIG) && (bus_wdata[1:0] == 2'b00);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_gnt && !stop_w) |=> (dma_req && $stable(dma_addr)));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_gnt && !stop_w) |=> (!dma_req || dma_addr == $past(dma_addr) + 32'd4));

    p_write_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> dma_rvalid);

    p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !stop_w) |=> state == ST_DONE);

    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_sel && bus_wr)) |=> irq);

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (state == ST_IDLE && !dma_req));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !dma_req);
endmodule

bind pke_ctrl pke_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dma_req(dma_req),
    .dma_gnt(dma_gnt), .dma_addr(dma_addr), .dma_rvalid(dma_rvalid),
    .sram_we(sram_we), .irq(irq), .state(state_q)
);

// File: tb/tb_pke_ctrl.sv
module tb_pke_ctrl;
    import pke_pkg::*;
    localparam int CALC = 16;
    localparam int AW   = 11;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        dma_req, dma_gnt = 1'b0, dma_rvalid;
    logic [31:0] dma_addr, dma_rdata;
    logic        sram_we, mem_cpu_access, irq;
    logic [AW-1:0] sram_addr;
    logic [31:0] sram_wdata;

    int errors = 0, checks = 0, n_acc = 0, cyc = 0;
    bit gnt_full = 1'b1;
    logic        acc_q = 1'b0;
    logic [31:0] addr_q = '0;
    int          exp_idx[$];
    logic [31:0] exp_dat[$];

    pke_ctrl #(.SRAM_AW(AW), .CALC_CYCLES(CALC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_gnt(dma_gnt),
        .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .mem_cpu_access(mem_cpu_access), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    // system memory model: one-cycle read latency
    always @(posedge clk) begin
        acc_q  <= dma_req && dma_gnt;
        addr_q <= dma_addr;
        if (dma_req && dma_gnt) n_acc <= n_acc + 1;
    end
    assign dma_rvalid = acc_q;
    assign dma_rdata  = mem_word(addr_q);

    always @(negedge clk) begin
        cyc = cyc + 1;
        dma_gnt = gnt_full || (cyc % 3 != 0);
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for SRAM writes
    always @(negedge clk) begin
        if (rst_n && sram_we) begin
            if (exp_idx.size() == 0) begin
                check(1'b0, "R5 unexpected sram write", 32'(sram_addr), 32'hFFFF_FFFF);
            end else begin
                int i;
                logic [31:0] d;
                i = exp_idx.pop_front();
                d = exp_dat.pop_front();
                check(32'(sram_addr) == 32'(i[AW-1:0]) && sram_wdata == d, "R5 sram write",
                      sram_wdata, d);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            report();
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        logic [31:0] d;
        rd(a, d);
        check(d == e, tag, d, e);
    endtask

    // driver: push the words a fetch must deliver
    task automatic expect_fetch(input logic [31:0] base, input int len);
        for (int k = 0; k < (len + 3) / 4; k++) begin
            exp_idx.push_back(k);
            exp_dat.push_back(mem_word(base + 32'(k * 4)));
        end
    endtask

    task automatic wait_irq(input int max);
        for (int k = 0; k < max && !irq; k++) @(negedge clk);
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_chk(OFF_TRIG, 0, "R1 trig");
        rd_chk(OFF_CMD, 0, "R1 cmd");
        rd_chk(OFF_KEYLEN, 0, "R1 keylen");
        rd_chk(OFF_STAT, 0, "R1 status");
        check(!irq && !dma_req, "R1 irq/req", {30'b0, irq, dma_req}, 0);

        // R2 register map and field packing
        wr(OFF_SRC, 32'h1000_0000);
        wr(OFF_LEN, 32'h0000_1800);
        wr(OFF_KEYLEN, {16'd17, 16'd2048});
        wr(OFF_MASK, 32'hFFFF_FFFF);
        wr(OFF_CMD, 32'hFFFF_FFFF);
        rd_chk(OFF_SRC, 32'h1000_0000, "R2 src");
        rd_chk(OFF_LEN, 32'h1800, "R2 len");
        rd_chk(OFF_KEYLEN, 32'h0011_0800, "R2 keylen exp[31:16] mod[15:0]");
        rd_chk(OFF_MASK, 32'h2, "R2 mask");
        rd_chk(OFF_CMD, 32'h130, "R2 cmd");
        check(mem_cpu_access, "R2 mem_cpu_access", 32'(mem_cpu_access), 1);

        // R3 trigger rejected when CPU owns memory or fill field wrong
        a0 = n_acc;
        wr(OFF_TRIG, 3);
        repeat (5) @(negedge clk);
        rd_chk(OFF_TRIG, 0, "R3 reject cpu-owned");
        wr(OFF_CMD, 32'h010);
        wr(OFF_TRIG, 3);
        repeat (5) @(negedge clk);
        rd_chk(OFF_TRIG, 0, "R3 reject fill 01");
        check(n_acc == a0, "R3 no reads", n_acc, a0);

        // R4 R5 R6 R7 full fetch with gaps in grant
        wr(OFF_CMD, 32'h030);
        wr(OFF_SRC, 32'h2000_0000);
        gnt_full = 1'b0;
        expect_fetch(32'h2000_0000, 32'h1800);
        a0 = n_acc;
        wr(OFF_TRIG, 3);
        rd_chk(OFF_TRIG, 3, "R3 accepted");
        repeat (20) @(negedge clk);
        wr(OFF_TRIG, 2);
        rd_chk(OFF_TRIG, 3, "R9 busy trigger ignored");
        wait_irq(10000);
        check(n_acc - a0 == 1536, "R4 read count", n_acc - a0, 1536);
        check(exp_idx.size() == 0, "R5 all words written", exp_idx.size(), 0);
        check(irq, "R7 irq raised", 32'(irq), 1);
        rd_chk(OFF_STAT, 2, "R6 status set");
        repeat (5) @(negedge clk);
        check(irq, "R7 irq held", 32'(irq), 1);
        wr(OFF_STAT, 0);
        check(irq, "R8 write 0 no clear", 32'(irq), 1);
        a0 = n_acc;
        wr(OFF_TRIG, 2);
        repeat (10) @(negedge clk);
        check(n_acc == a0, "R9 trigger in done ignored", n_acc, a0);
        wr(OFF_STAT, 2);
        check(!irq, "R8 w1c clears irq", 32'(irq), 0);
        rd_chk(OFF_STAT, 0, "R8 status cleared");
        wr(OFF_TRIG, 0);
        rd_chk(OFF_TRIG, 0, "R10 stop to idle");

        // R4 rounding, fetch only: 10 bytes -> 3 words, no completion
        gnt_full = 1'b1;
        wr(OFF_SRC, 32'h3000_0040);
        wr(OFF_LEN, 10);
        expect_fetch(32'h3000_0040, 10);
        a0 = n_acc;
        wr(OFF_TRIG, 2);
        repeat (20) @(negedge clk);
        check(n_acc - a0 == 3, "R4 rounded word count", n_acc - a0, 3);
        check(exp_idx.size() == 0, "R5 short fetch written", exp_idx.size(), 0);
        rd_chk(OFF_STAT, 0, "R6 fetch-only no status");
        wr(OFF_TRIG, 0);

        // R12 zero length then compute
        wr(OFF_LEN, 0);
        a0 = n_acc;
        wr(OFF_TRIG, 3);
        wait_irq(100);
        check(n_acc == a0, "R12 zero-length no reads", n_acc, a0);
        check(irq, "R12 compute follows empty fetch", 32'(irq), 1);
        wr(OFF_STAT, 2);
        wr(OFF_TRIG, 0);

        // R6 exact compute latency, compute only
        a0 = n_acc;
        wr(OFF_TRIG, 1);
        repeat (CALC - 1) @(negedge clk);
        check(!irq, "R6 irq one cycle early", 32'(irq), 0);
        @(negedge clk);
        check(irq, "R6 irq at CALC_CYCLES", 32'(irq), 1);
        check(n_acc == a0, "R6 compute-only no reads", n_acc, a0);
        wr(OFF_STAT, 2);
        wr(OFF_TRIG, 0);

        // R7 mask gating
        wr(OFF_MASK, 0);
        wr(OFF_TRIG, 1);
        repeat (CALC + 2) @(negedge clk);
        check(!irq, "R7 masked irq low", 32'(irq), 0);
        rd_chk(OFF_STAT, 2, "R7 status set while masked");
        wr(OFF_MASK, 2);
        check(irq, "R7 unmask raises irq", 32'(irq), 1);
        wr(OFF_STAT, 2);
        wr(OFF_TRIG, 0);

        // R10 abort in middle of a fetch, then restart
        wr(OFF_SRC, 32'h4000_0000);
        wr(OFF_LEN, 32'h1800);
        expect_fetch(32'h4000_0000, 32'h1800);
        wr(OFF_TRIG, 3);
        repeat (30) @(negedge clk);
        wr(OFF_TRIG, 0);
        check(!dma_req, "R10 req dropped", 32'(dma_req), 0);
        exp_idx.delete();
        exp_dat.delete();
        a0 = n_acc;
        repeat (40) @(negedge clk);
        check(n_acc == a0 && !irq, "R10 stays idle", n_acc, a0);
        rd_chk(OFF_TRIG, 0, "R10 trig reads 0");
        wr(OFF_LEN, 8);
        expect_fetch(32'h4000_0000, 8);
        wr(OFF_TRIG, 2);
        repeat (10) @(negedge clk);
        check(n_acc - a0 == 2, "R10 restart accepted", n_acc - a0, 2);
        wr(OFF_TRIG, 0);

        // R11 modulus length limit
        wr(OFF_KEYLEN, {16'd3, 16'd4097});
        wr(OFF_TRIG, 1);
        repeat (CALC + 2) @(negedge clk);
        rd_chk(OFF_TRIG, 0, "R11 4097 rejected");
        check(!irq, "R11 no completion", 32'(irq), 0);
        wr(OFF_KEYLEN, {16'd3, 16'd4096});
        wr(OFF_TRIG, 1);
        wait_irq(100);
        check(irq, "R11 4096 accepted", 32'(irq), 1);

        report();
    end
endmodule